// File: doc/BRIEF.md
# Reset Cause Status Register

This block is an 8-bit control and status register. It records what caused the most recent device reset, and it follows the power-down and watchdog state of the core. Its inputs are single-cycle event strobes: power-on reset, brown-out reset, watchdog time-out, sleep instruction, watchdog-clear instruction and software-reset instruction. A configuration input says whether brown-out detection is enabled. Firmware reaches the register over a simple bus with read enable, write enable, write data and read data.

Each flag has its own rules. Some flags are cleared by a hardware event and stay cleared until firmware writes them back to 1. Other flags are driven only by hardware and cannot be written. The interrupt-priority enable bit is an ordinary read/write control bit, and it is also driven onto an output pin for the interrupt logic. The block does not generate resets, it does not contain the watchdog timer, and it does not contain the interrupt controller.

Top module: `rcs_status_reg`

## Requirements
- R1: After `rst` or a `por_evt`, the register reads `{ipen=0, 2'b00, sw=1, wdt=1, pd=1, pwr=0, brn=bor_en}`, which is 8'h1D when `bor_en`=1 and 8'h1C when `bor_en`=0. The bit positions are: bit 7 is ipen, bits 6:5 are pad bits, bit 4 is sw, bit 3 is wdt, bit 2 is pd, bit 1 is pwr and bit 0 is brn.
- R2: Bits 6 and 5 always read 0, and writes to them have no effect.
- R3: Bit 7 (ipen) is read/write and is always equal to the `irq_prio_en` output.
- R4: Bit 4 (sw) is cleared to 0 by `swrst_evt`. Firmware can write it to any value.
- R5: Bit 3 (wdt) is cleared to 0 by `wdt_to_evt`. It is set to 1 by `clrwdt_evt` or by `sleep_evt`. If a time-out and one of those events occur in the same cycle, the time-out wins. Writes do not change this bit.
- R6: Bit 2 (pd) is cleared to 0 by `sleep_evt` and set to 1 by `clrwdt_evt`. If both occur in the same cycle, the sleep wins. Writes do not change this bit.
- R7: Bit 1 (pwr) is cleared to 0 by a power-on event. After that it holds whatever value firmware writes.
- R8: Bit 0 (brn) is cleared to 0 by `bor_evt` only while `bor_en`=1. While `bor_en`=0, `bor_evt` has no effect on it. Firmware can write it.
- R9: If a hardware event and a firmware write hit the same bit in the same cycle, the event's value is the one stored.
- R10: While `rd_en`=1, `rd_data` shows the current register value combinationally. While `rd_en`=0, `rd_data` is 0. A write becomes visible only after the next clock edge.
- R11: A `por_evt` overrides every other event and any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the power-on state |
| por_evt | input | 1 | Power-on reset strobe |
| bor_evt | input | 1 | Brown-out reset strobe |
| wdt_to_evt | input | 1 | Watchdog time-out strobe |
| sleep_evt | input | 1 | Sleep instruction strobe |
| clrwdt_evt | input | 1 | Watchdog-clear instruction strobe |
| swrst_evt | input | 1 | Software-reset instruction strobe |
| bor_en | input | 1 | Brown-out detection enabled (configuration) |
| rd_en | input | 1 | Read enable |
| wr_en | input | 1 | Write enable |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| irq_prio_en | output | 1 | Interrupt-priority enable control bit |

## Verification
The assertions assume that every event strobe is sampled on a clock edge with reset low. They also assume that `bor_en` is a level that is valid in the same cycle as a power-on or brown-out event. No other relation between the inputs is assumed, so any mix of strobes, including contradictory ones, is legal. The bench drives every input at the falling edge, so these assumptions hold by construction. It sweeps all combinations of event strobes together with writes and configuration levels, and it compares each result against a flag model it computes on its own.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    localparam int REG_W  = 8;
    localparam int IPEN_B = 7;
    localparam int PADH_B = 6;
    localparam int PADL_B = 5;
    localparam int SW_B   = 4;
    localparam int WDT_B  = 3;
    localparam int PD_B   = 2;
    localparam int PWR_B  = 1;
    localparam int BRN_B  = 0;
    localparam int CTRL_W = 1;

    typedef struct packed {
        logic ipen;
        logic sw;
        logic wdt;
        logic pd;
        logic pwr;
        logic brn;
    } rcs_flags_t;

    function automatic logic [REG_W-1:0] rcs_pack(input rcs_flags_t f);
        logic [REG_W-1:0] v;
        v         = '0;
        v[IPEN_B] = f.ipen;
        v[SW_B]   = f.sw;
        v[WDT_B]  = f.wdt;
        v[PD_B]   = f.pd;
        v[PWR_B]  = f.pwr;
        v[BRN_B]  = f.brn;
        return v;
    endfunction
endpackage

// File: rtl/rcs_ctrl_bits.sv
module rcs_ctrl_bits #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         por,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || por)
                q[g] <= 1'b0;
            else if (wr_en)
                q[g] <= wr_val[g];
        end

        assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !por) |=> q[g] == $past(wr_val[g]));
    end
endmodule

// File: rtl/rcs_wdt_flags.sv
module rcs_wdt_flags (
    input  logic clk,
    input  logic rst,
    input  logic por,
    input  logic wdt_to,
    input  logic sleep,
    input  logic clrwdt,
    output logic wdt_f,
    output logic pd_f
);
    always_ff @(posedge clk) begin
        if (rst || por) begin
            wdt_f <= 1'b1;
            pd_f  <= 1'b1;
        end else begin
            if (wdt_to)
                wdt_f <= 1'b0;
            else if (sleep || clrwdt)
                wdt_f <= 1'b1;
            if (sleep)
                pd_f <= 1'b0;
            else if (clrwdt)
                pd_f <= 1'b1;
        end
    end

    assert_wdt_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (!por && wdt_to) |=> !wdt_f);
    assert_wdt_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!por && !wdt_to && !sleep && !clrwdt) |=> $stable(wdt_f));
    assert_pd_sleep_R6: assert property (@(posedge clk) disable iff (rst)
        (!por && sleep) |=> !pd_f);
    assert_pd_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!por && !sleep && !clrwdt) |=> $stable(pd_f));
endmodule

// File: rtl/rcs_reset_flags.sv
module rcs_reset_flags (
    input  logic clk,
    input  logic rst,
    input  logic por,
    input  logic bor,
    input  logic swrst,
    input  logic bor_en,
    input  logic wr_en,
    input  logic wr_sw,
    input  logic wr_pwr,
    input  logic wr_brn,
    output logic sw_f,
    output logic pwr_f,
    output logic brn_f
);
    logic bor_hit;
    assign bor_hit = bor && bor_en;

    always_ff @(posedge clk) begin
        if (rst || por) begin
            sw_f  <= 1'b1;
            pwr_f <= 1'b0;
            brn_f <= bor_en;
        end else begin
            if (swrst)
                sw_f <= 1'b0;
            else if (wr_en)
                sw_f <= wr_sw;
            if (wr_en)
                pwr_f <= wr_pwr;
            if (bor_hit)
                brn_f <= 1'b0;
            else if (wr_en)
                brn_f <= wr_brn;
        end
    end

    assert_sw_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (!por && swrst) |=> !sw_f);
    assert_por_value_R11: assert property (@(posedge clk) disable iff (rst)
        por |=> (sw_f && !pwr_f && brn_f == $past(bor_en)));
    assert_brn_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (!por && bor && bor_en) |=> !brn_f);
    assert_brn_ignore_R8: assert property (@(posedge clk) disable iff (rst)
        (!por && !bor_en && !wr_en) |=> $stable(brn_f));
    assert_pwr_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!por && !wr_en) |=> $stable(pwr_f));
endmodule

// File: rtl/rcs_status_reg.sv
module rcs_status_reg
    import rcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             por_evt,
    input  logic             bor_evt,
    input  logic             wdt_to_evt,
    input  logic             sleep_evt,
    input  logic             clrwdt_evt,
    input  logic             swrst_evt,
    input  logic             bor_en,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             irq_prio_en
);
    rcs_flags_t       flags;
    logic [REG_W-1:0] reg_val;
    logic [CTRL_W-1:0] ctrl_q;
    logic             unused_pad;

    assign unused_pad = ^{wr_data[PADH_B], wr_data[PADL_B], wr_data[WDT_B], wr_data[PD_B]};

    rcs_ctrl_bits #(.W(CTRL_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .por    (por_evt),
        .wr_en  (wr_en),
        .wr_val (wr_data[IPEN_B +: CTRL_W]),
        .q      (ctrl_q)
    );

    rcs_wdt_flags u_wdt (
        .clk    (clk),
        .rst    (rst),
        .por    (por_evt),
        .wdt_to (wdt_to_evt),
        .sleep  (sleep_evt),
        .clrwdt (clrwdt_evt),
        .wdt_f  (flags.wdt),
        .pd_f   (flags.pd)
    );

    rcs_reset_flags u_rst (
        .clk    (clk),
        .rst    (rst),
        .por    (por_evt),
        .bor    (bor_evt),
        .swrst  (swrst_evt),
        .bor_en (bor_en),
        .wr_en  (wr_en),
        .wr_sw  (wr_data[SW_B]),
        .wr_pwr (wr_data[PWR_B]),
        .wr_brn (wr_data[BRN_B]),
        .sw_f   (flags.sw),
        .pwr_f  (flags.pwr),
        .brn_f  (flags.brn)
    );

    assign flags.ipen  = ctrl_q[0];
    assign reg_val     = rcs_pack(flags);
    assign rd_data     = rd_en ? reg_val : '0;
    assign irq_prio_en = ctrl_q[0];

    assert_pad_zero_R2: assert property (@(posedge clk) disable iff (rst)
        rd_data[PADH_B:PADL_B] == 2'b00);
    assert_ipen_pin_R3: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> rd_data[IPEN_B] == irq_prio_en);
    assert_por_ipen_R11: assert property (@(posedge clk) disable iff (rst)
        por_evt |=> !irq_prio_en);
endmodule

// File: tb/sim_rcs_status_reg.sv
module sim_rcs_status_reg;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       por_evt = 0, bor_evt = 0, wdt_to_evt = 0, sleep_evt = 0;
    logic       clrwdt_evt = 0, swrst_evt = 0, bor_en = 1, rd_en = 1, wr_en = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_prio_en;

    int checks = 0;
    int errors = 0;
    logic [7:0] model;

    rcs_status_reg u0 (
        .clk(clk), .rst(rst), .por_evt(por_evt), .bor_evt(bor_evt),
        .wdt_to_evt(wdt_to_evt), .sleep_evt(sleep_evt), .clrwdt_evt(clrwdt_evt),
        .swrst_evt(swrst_evt), .bor_en(bor_en), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq_prio_en(irq_prio_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench model: bit7 ipen, 4 sw, 3 wdt, 2 pd, 1 pwr, 0 brn.
    function automatic logic [7:0] por_state(input logic be);
        return {1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, be};
    endfunction

    function automatic logic [7:0] step(input logic [7:0] s, input logic [5:0] ev,
                                        input logic be, input logic we, input logic [7:0] wd);
        logic [7:0] n;
        // ev: 0 por, 1 bor, 2 wdt, 3 sleep, 4 clr, 5 swrst
        if (ev[0]) return por_state(be);            // R11
        n = s;
        if (we) begin
            n[7] = wd[7]; n[4] = wd[4]; n[1] = wd[1]; n[0] = wd[0];
        end
        if (ev[5]) n[4] = 1'b0;                      // R9: event beats write
        if (ev[1] && be) n[0] = 1'b0;
        if (ev[2]) n[3] = 1'b0;
        else if (ev[3] || ev[4]) n[3] = 1'b1;
        if (ev[3]) n[2] = 1'b0;
        else if (ev[4]) n[2] = 1'b1;
        return n;
    endfunction

    function automatic string req_of(input logic [7:0] d);
        if (d[0]) return "R8";
        if (d[1]) return "R7";
        if (d[2]) return "R6";
        if (d[3]) return "R5";
        if (d[4]) return "R4";
        if (d[6] || d[5]) return "R2";
        return "R3";
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] ev, input logic be, input logic we, input logic [7:0] wd);
        por_evt = ev[0]; bor_evt = ev[1]; wdt_to_evt = ev[2];
        sleep_evt = ev[3]; clrwdt_evt = ev[4]; swrst_evt = ev[5];
        bor_en = be; wr_en = we; wr_data = wd;
    endtask

    task automatic cycle(input logic [5:0] ev, input logic be, input logic we, input logic [7:0] wd);
        drive(ev, be, we, wd);
        @(negedge clk);
        model = step(model, ev, be, we, wd);
        drive(6'b0, be, 1'b0, 8'h00);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset with brown-out enabled and disabled
        bor_en = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        check("R1 reset bor_en=0", rd_data, 8'h1C);
        check("R3 pin after reset", {7'b0, irq_prio_en}, 8'h00);
        rst = 1; bor_en = 1;
        @(negedge clk);
        rst = 0;
        check("R1 reset bor_en=1", rd_data, 8'h1D);
        model = 8'h1D;

        // R10: read enable low gives zero
        rd_en = 0; #1;
        check("R10 rd_en low", rd_data, 8'h00);
        rd_en = 1;

        // R10: write not visible before the edge, visible after
        drive(6'b0, 1'b1, 1'b1, 8'hFF); #1;
        check("R10 write before edge", rd_data, 8'h1D);
        @(negedge clk);
        model = step(model, 6'b0, 1'b1, 1'b1, 8'hFF);
        drive(6'b0, 1'b1, 1'b0, 8'h00);
        check("R2 pad ignores write", rd_data, 8'h9F);
        check("R3 pin follows write", {7'b0, irq_prio_en}, 8'h01);

        // R9: brown-out event beats write of 1
        cycle(6'b000010, 1'b1, 1'b1, 8'h81);
        check("R9 bor beats write", rd_data, model);
        // R8: bor ignored when disabled
        cycle(6'b0, 1'b1, 1'b1, 8'h81);
        cycle(6'b000010, 1'b0, 1'b0, 8'h00);
        check("R8 bor ignored when disabled", rd_data[0] ? 8'h01 : 8'h00, 8'h01);
        // R6/R5: sleep with clear -> pd 0, wdt 1
        cycle(6'b011000, 1'b1, 1'b0, 8'h00);
        check("R6 sleep beats clear", {6'b0, rd_data[3:2]}, 8'h02);
        // R5: time-out beats clear
        cycle(6'b010100, 1'b1, 1'b0, 8'h00);
        check("R5 timeout beats clear", {6'b0, rd_data[3:2]}, 8'h01);
        // R11: power-on beats everything
        cycle(6'b111111, 1'b0, 1'b1, 8'hFF);
        check("R11 por overrides", rd_data, 8'h1C);

        // Sweep R1..R11: all event mixes against writes and configuration
        for (int i = 0; i < 2048; i++) begin
            logic [5:0] ev;
            logic [7:0] wd;
            ev    = {i[5:1], (i[10:8] == 3'b101) && i[0]};
            wd    = 8'(i * 53) ^ 8'(i >> 3);
            cycle(ev, i[6], i[7], wd);
            checks++;
            if (rd_data !== model) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h vec=%0d",
                         req_of(rd_data ^ model), rd_data, model, i);
            end
            if (irq_prio_en !== model[7]) begin
                errors++;
                $display("FAIL R3 pin actual=%b expected=%b", irq_prio_en, model[7]);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule